// File: doc/BRIEF.md
# Redundant Reference Clock Failover Controller

This block decides which of two reference clocks feeds a downstream phase-locked loop. It samples both references and the loop's feedback clock with a fast local clock, and it raises a latched fault flag for any reference that shows no transition during a whole feedback period. A feedback clock that stops raises both flags at once.

In automatic mode, the first failure of the reference that is in use moves the selection to the other reference. The selection then stays there whatever happens next. In manual mode the selection simply follows the preferred-reference input. In both modes the fault flags keep detecting and latching.

A falling edge on the active-low alarm reset makes a single one-cycle clear. That clear drops both flags and puts the selection back under the preferred-reference input.

Every asynchronous input passes through a two-flop synchronizer. The local clock must run at least four times faster than the fastest monitored clock.

The selection logic is a three-state machine:
- `ST_TRACK`: the selection equals the preferred-reference input.
- `ST_HOLD0`: the selection is frozen on reference 0.
- `ST_HOLD1`: the selection is frozen on reference 1.

Transitions:
- **failover**: `ST_TRACK` to the hold state of the other reference. This happens in automatic mode when the selected reference fails first and the other one is healthy.
- **freeze**: `ST_TRACK` to the hold state of the current reference. This happens in automatic mode on any other new failure.
- **clear**: any state to `ST_TRACK`, on the alarm one-shot.

Top module: `refclk_failover`

## Requirements
- R1: After reset, both fault flags are low and the selection equals the preferred-reference input (0 selects reference 0, 1 selects reference 1).
- R2: A reference that holds a constant level through a full feedback period gets its fault flag set within two feedback periods. A reference that keeps toggling is never flagged.
- R3: If the feedback clock shows no edge for FB_TIMEOUT local-clock cycles, both fault flags are set.
- R4: A fault flag stays high after its reference recovers, until the next alarm clear.
- R5: Only a high-to-low transition of the alarm reset input clears the flags. A held low level does not stop new flags from latching, and the following rising edge clears nothing.
- R6: The alarm clear drops both flags and makes the selection equal the preferred-reference input again.
- R7: With manual override high, the selection always equals the preferred-reference input, and the fault flags still latch.
- R8: With manual override low, the first failure of the selected reference switches the selection to the other reference. The selection then ignores the preferred-reference input until the next clear.
- R9: With manual override low, a failure of the unselected reference freezes the selection where it is. A later failure of the other reference does not toggle it back.
- R10: A loss of the feedback clock in automatic mode leaves the selection on its current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast local sampling clock |
| rst_ni | input | 1 | Active-low reset of the local clock domain |
| ref0_i | input | 1 | Reference clock 0 |
| ref1_i | input | 1 | Reference clock 1 |
| fb_i | input | 1 | Feedback clock from the loop output |
| prim_sel_i | input | 1 | Preferred reference: 0 for ref0, 1 for ref1 |
| man_ovr_i | input | 1 | 1 disables automatic failover |
| alarm_rst_ni | input | 1 | Active-low alarm clear, acting on the falling edge |
| bad0_o | output | 1 | Latched fault flag of reference 0 |
| bad1_o | output | 1 | Latched fault flag of reference 1 |
| sel_o | output | 1 | Reference in use: 0 for ref0, 1 for ref1 |

## Verification
The hardest situation to reach is a second failure that arrives after the selection has already frozen. It takes two references stopped in sequence with the preferred input held steady in between. The bench first stalls the unselected reference and lets that flag latch. It then stalls the selected one, so the check can confirm that the frozen selection does not flip.

A second hard case is a flag latching while the alarm input is held low. The bench keeps the alarm low across a whole reference stall and then confirms that the rising edge of the alarm leaves the flag set.

// File: rtl/refclk_failover_pkg.sv
package refclk_failover_pkg;
    localparam int NUM_REF = 2;

    typedef enum logic [1:0] {
        ST_TRACK = 2'd0,
        ST_HOLD0 = 2'd1,
        ST_HOLD1 = 2'd2
    } sel_state_t;
endpackage

// File: rtl/rfo_sync.sv
module rfo_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stg_q [STAGES];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rfo_act_mon.sv
module rfo_act_mon (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic ref_s_i,
    input  logic fb_rise_i,
    output logic miss_o
);
    logic ref_d_q;
    logic act_q;
    logic armed_q;
    logic ref_edge;

    assign ref_edge = ref_s_i ^ ref_d_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ref_d_q <= 1'b0;
            act_q   <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            ref_d_q <= ref_s_i;
            if (clr_i) begin
                act_q   <= 1'b0;
                armed_q <= 1'b0;
            end else if (fb_rise_i) begin
                act_q   <= ref_edge;
                armed_q <= 1'b1;
            end else if (ref_edge) begin
                act_q <= 1'b1;
            end
        end
    end

    // window ends at a feedback rise: a silent, armed window is a miss
    assign miss_o = fb_rise_i && armed_q && !(act_q || ref_edge) && !clr_i;
endmodule

// File: rtl/rfo_fb_watch.sv
module rfo_fb_watch #(
    parameter int FB_TIMEOUT = 48
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fb_s_i,
    output logic fb_rise_o,
    output logic fb_lost_o
);
    localparam int CW = $clog2(FB_TIMEOUT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(FB_TIMEOUT);

    logic          fb_d_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fb_d_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            fb_d_q <= fb_s_i;
            if (fb_s_i != fb_d_q)  cnt_q <= '0;
            else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign fb_rise_o = fb_s_i & ~fb_d_q;
    assign fb_lost_o = (cnt_q == LIMIT);
endmodule

// File: rtl/refclk_failover.sv
module refclk_failover
    import refclk_failover_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FB_TIMEOUT  = 48
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ref0_i,
    input  logic ref1_i,
    input  logic fb_i,
    input  logic prim_sel_i,
    input  logic man_ovr_i,
    input  logic alarm_rst_ni,
    output logic bad0_o,
    output logic bad1_o,
    output logic sel_o
);
    localparam int NSYNC = NUM_REF + 4;

    logic [NSYNC-1:0]   raw_in, sync_out;
    logic [NUM_REF-1:0] ref_s, miss, set_vec, new_fail, bad_q;
    logic fb_s, prim_s, ovr_s, alarm_s, alarm_d_q;
    logic fb_rise, fb_lost, clr_pulse;
    logic fail_cur, other_ok, target;
    sel_state_t st_q, st_next;

    assign raw_in = {alarm_rst_ni, man_ovr_i, prim_sel_i, fb_i, ref1_i, ref0_i};

    rfo_sync #(
        .WIDTH  (NSYNC),
        .STAGES (SYNC_STAGES),
        .RST_VAL({1'b1, {(NSYNC-1){1'b0}}})
    ) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (raw_in),
        .q_o   (sync_out)
    );

    assign ref_s   = sync_out[NUM_REF-1:0];
    assign fb_s    = sync_out[NUM_REF];
    assign prim_s  = sync_out[NUM_REF+1];
    assign ovr_s   = sync_out[NUM_REF+2];
    assign alarm_s = sync_out[NUM_REF+3];

    rfo_fb_watch #(.FB_TIMEOUT(FB_TIMEOUT)) u_fbw (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .fb_s_i   (fb_s),
        .fb_rise_o(fb_rise),
        .fb_lost_o(fb_lost)
    );

    for (genvar g = 0; g < NUM_REF; g++) begin : g_mon
        rfo_act_mon u_mon (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .clr_i    (clr_pulse),
            .ref_s_i  (ref_s[g]),
            .fb_rise_i(fb_rise),
            .miss_o   (miss[g])
        );
    end

    assign clr_pulse = alarm_d_q & ~alarm_s;
    assign set_vec   = miss | {NUM_REF{fb_lost}};
    assign new_fail  = set_vec & ~bad_q;

    assign fail_cur = prim_s ? new_fail[1] : new_fail[0];
    assign other_ok = prim_s ? !(set_vec[0] | bad_q[0]) : !(set_vec[1] | bad_q[1]);
    assign target   = (fail_cur && other_ok) ? !prim_s : prim_s;

    always_comb begin
        st_next = st_q;
        if (clr_pulse) begin
            st_next = ST_TRACK;                       // clear
        end else begin
            unique case (st_q)
                ST_TRACK: if (!ovr_s && (|new_fail))  // failover or freeze
                              st_next = target ? ST_HOLD1 : ST_HOLD0;
                ST_HOLD0: st_next = ST_HOLD0;
                ST_HOLD1: st_next = ST_HOLD1;
                default:  st_next = ST_TRACK;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= ST_TRACK;
        else         st_q <= st_next;
    end

    // latched status outputs
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bad_q     <= '0;
            alarm_d_q <= 1'b1;
        end else begin
            alarm_d_q <= alarm_s;
            if (clr_pulse) bad_q <= '0;
            else           bad_q <= bad_q | set_vec;
        end
    end

    always_comb begin
        sel_o = prim_s;
        if (!ovr_s) begin
            unique case (st_q)
                ST_HOLD0: sel_o = 1'b0;
                ST_HOLD1: sel_o = 1'b1;
                default:  sel_o = prim_s;
            endcase
        end
    end

    assign bad0_o = bad_q[0];
    assign bad1_o = bad_q[1];
endmodule

// File: rtl/refclk_failover_chk.sv
module refclk_failover_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       bad0_o,
    input logic       bad1_o,
    input logic       sel_o,
    input logic       prim_s,
    input logic       ovr_s,
    input logic       clr_pulse,
    input logic       fb_lost,
    input logic [1:0] st_q
);
    a_r4_flag0_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bad0_o && !clr_pulse) |=> bad0_o);
    a_r4_flag1_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bad1_o && !clr_pulse) |=> bad1_o);
    a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_pulse |=> !clr_pulse);
    a_r6_clear_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_pulse |=> (!bad0_o && !bad1_o && st_q == 2'd0));
    a_r3_fb_loss: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fb_lost && !clr_pulse) |=> (bad0_o && bad1_o));
    a_r7_override: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovr_s |-> (sel_o == prim_s));
    a_r8_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q != 2'd0 && !ovr_s && !clr_pulse) |=> (ovr_s || $stable(sel_o)));
endmodule

bind refclk_failover refclk_failover_chk u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bad0_o   (bad0_o),
    .bad1_o   (bad1_o),
    .sel_o    (sel_o),
    .prim_s   (prim_s),
    .ovr_s    (ovr_s),
    .clr_pulse(clr_pulse),
    .fb_lost  (fb_lost),
    .st_q     (st_q)
);

// File: tb/refclk_failover_bench.sv
`timescale 1ns/1ps
module refclk_failover_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref0 = 1'b0, ref1 = 1'b0, fb = 1'b0;
    logic prim = 1'b0, ovr = 1'b0, alarm_n = 1'b1;
    logic bad0, bad1, sel;
    logic run0 = 1'b1, run1 = 1'b1, runfb = 1'b1;
    int n_chk = 0, n_bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;                 // 125 MHz
    always #64  if (run0)  ref0 = ~ref0;  // 16-cycle period
    always #72  if (run1)  ref1 = ~ref1;  // 18-cycle period
    always #128 if (runfb) fb   = ~fb;    // 32-cycle period

    refclk_failover u_refclk_failover (
        .clk_i(clk), .rst_ni(rst_n), .ref0_i(ref0), .ref1_i(ref1), .fb_i(fb),
        .prim_sel_i(prim), .man_ovr_i(ovr), .alarm_rst_ni(alarm_n),
        .bad0_o(bad0), .bad1_o(bad1), .sel_o(sel)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {bad1,bad0,sel} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic pulse_alarm();
        alarm_n = 1'b0; wait_cyc(6);
        alarm_n = 1'b1; wait_cyc(6);
    endtask

    task automatic t_reset();
        chk("R1 reset state", {bad1, bad0, sel}, 3'b000);
    endtask

    task automatic t_normal();
        wait_cyc(300);
        chk("R2 toggling refs not flagged", {bad1, bad0, sel}, 3'b000);
        prim = 1'b1; wait_cyc(6);
        chk("R1 selection follows preferred=1", {bad1, bad0, sel}, 3'b001);
        prim = 1'b0; wait_cyc(6);
        chk("R1 selection follows preferred=0", {bad1, bad0, sel}, 3'b000);
    endtask

    task automatic t_failover();
        run0 = 1'b0; wait_cyc(150);
        chk("R2 R8 stuck ref0 flagged, failover to ref1", {bad1, bad0, sel}, 3'b011);
        prim = 1'b1; wait_cyc(6); prim = 1'b0; wait_cyc(6);
        chk("R8 selection ignores preferred input", {bad1, bad0, sel}, 3'b011);
        run0 = 1'b1; wait_cyc(150);
        chk("R4 flag stays after recovery", {bad1, bad0, sel}, 3'b011);
        prim = 1'b1; wait_cyc(4);
        pulse_alarm(); wait_cyc(100);
        chk("R6 clear loads preferred=1", {bad1, bad0, sel}, 3'b001);
        prim = 1'b0; wait_cyc(6);
        chk("R6 tracking after clear", {bad1, bad0, sel}, 3'b000);
    endtask

    task automatic t_alarm_level();
        alarm_n = 1'b0; wait_cyc(10);
        run1 = 1'b0; wait_cyc(150);
        chk("R5 flag latches while alarm held low", {bad1, bad0, sel}, 3'b100);
        run1 = 1'b1; wait_cyc(50);
        alarm_n = 1'b1; wait_cyc(20);
        chk("R5 rising alarm edge clears nothing", {bad1, bad0, sel}, 3'b100);
        pulse_alarm(); wait_cyc(100);
        chk("R6 falling edge clears", {bad1, bad0, sel}, 3'b000);
    endtask

    task automatic t_no_toggle();
        run1 = 1'b0; wait_cyc(150);
        chk("R9 unselected fail freezes on ref0", {bad1, bad0, sel}, 3'b100);
        prim = 1'b1; wait_cyc(6);
        chk("R9 frozen selection ignores preferred", {bad1, bad0, sel}, 3'b100);
        prim = 1'b0;
        run0 = 1'b0; wait_cyc(150);
        chk("R9 second failure does not toggle", {bad1, bad0, sel}, 3'b110);
        run0 = 1'b1; run1 = 1'b1; wait_cyc(50);
        pulse_alarm(); wait_cyc(100);
        chk("R6 clear after double failure", {bad1, bad0, sel}, 3'b000);
    endtask

    task automatic t_override();
        ovr = 1'b1; wait_cyc(6);
        run0 = 1'b0; wait_cyc(150);
        chk("R7 flag latches under override, sel stays", {bad1, bad0, sel}, 3'b010);
        prim = 1'b1; wait_cyc(6);
        chk("R7 override follows preferred=1", {bad1, bad0, sel}, 3'b011);
        prim = 1'b0; wait_cyc(6);
        chk("R7 override follows preferred=0", {bad1, bad0, sel}, 3'b010);
        run0 = 1'b1; wait_cyc(50);
        pulse_alarm(); wait_cyc(100);
        ovr = 1'b0; wait_cyc(6);
        chk("R6 clear after override test", {bad1, bad0, sel}, 3'b000);
    endtask

    task automatic t_fb_loss();
        runfb = 1'b0; wait_cyc(120);
        chk("R3 R10 fb loss flags both, selection kept", {bad1, bad0, sel}, 3'b110);
        runfb = 1'b1; wait_cyc(100);
        pulse_alarm(); wait_cyc(100);
        chk("R6 clear after fb recovery", {bad1, bad0, sel}, 3'b000);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(4);
        t_reset();
        t_normal();
        t_failover();
        t_alarm_level();
        t_no_toggle();
        t_override();
        t_fb_loss();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule